// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host run single clause-22 management transactions against an external PHY over the two-wire MDC/MDIO bus. Software programs a clock divisor and an enable flag, loads a 16-bit value for writes, then issues one packed command word naming the PHY, the PHY register and the direction, with a start bit. The block serializes the whole frame, drives MDC, and releases the data line for the PHY's answer on reads.

Software polls a ready flag in the command register before issuing a command and again to learn when it has finished. The received 16-bit value is then read from its own register. Only one frame runs at a time, and MDC toggles only while a frame is in flight.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration register reads 0x0000001D, which is divisor 29 with the enable clear. The command register reads 0x00000080, meaning ready with all fields zero. The read-data register reads 0. MDC, the MDIO output enable and busy are all low.
- R2: There are four registers. Configuration is at 0x500, with the divisor in bits 5:0 and the enable in bit 6. Command is at 0x504. Write data is at 0x508, in bits 15:0. Read data is at 0x50C, in bits 15:0. Configuration and write data read back what was written.
- R3: In the command word, bits 28:24 hold the PHY address and bits 20:16 hold the register address. Bit 15 set selects a read, and otherwise the frame is a write (bit 14). Bit 11 starts the frame. Reading the command register returns the stored fields, with bit 15 set for a read or bit 14 set for a write, bit 11 clear, and bit 7 set only when no frame is running.
- R4: MDC is low whenever no frame runs. Its first rising edge comes divisor+1 clocks after the start is accepted, and its period is 2×(divisor+1) clocks.
- R5: A frame is 64 bits sent MSB first: 32 ones, then 01, then opcode (10 read, 01 write), then the 5-bit PHY address, then the 5-bit register address, then turnaround (10 on writes), then 16 data bits. A write sends the write-data register.
- R6: On a read, the MDIO output enable drops from the first turnaround bit (bit 46) to the end of the frame. Data bits 48..63 are sampled on rising MDC edges and shifted, MSB first, into the read-data register.
- R7: A start is ignored while the enable bit is clear. A command write that arrives while a frame runs has no effect: the frame on the wire and the stored command fields are unchanged.
- R8: A read with no PHY driving the pulled-up line leaves 0xFFFF in the read-data register.
- R9: MDIO changes only while MDC is low, so it is stable across every high phase of MDC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| busy | output | 1 | High while a frame is running |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 6-bit divisor that resets to 29, and a 32-bit preamble, which gives full 64-bit frames. At run time it programs the divisor to 0, 1, 2, 3 and 29. This covers the one-clock MDC half period, odd and even counter limits, and the reset divisor itself. A PHY model in the bench answers reads or stays silent, and a command is injected in the middle of a frame to test the busy guard.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Register byte offsets (host-visible layout)
    localparam logic [11:0] OFS_CFG  = 12'h500;
    localparam logic [11:0] OFS_CTRL = 12'h504;
    localparam logic [11:0] OFS_WDAT = 12'h508;
    localparam logic [11:0] OFS_RDAT = 12'h50C;

    // Field positions
    localparam int CFG_EN_BIT   = 6;
    localparam int CTRL_PHY_LSB = 24;
    localparam int CTRL_REG_LSB = 16;
    localparam int CTRL_RD_BIT  = 15;
    localparam int CTRL_WR_BIT  = 14;
    localparam int CTRL_GO_BIT  = 11;
    localparam int CTRL_RDY_BIT = 7;

    // Opcode as sent on the wire; bit 1 maps to CTRL_RD_BIT, bit 0 to CTRL_WR_BIT
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        mdio_op_e   op;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_cmd(input logic [31:0] word);
        mdio_cmd_t c;
        c.phy   = word[CTRL_PHY_LSB +: 5];
        c.regad = word[CTRL_REG_LSB +: 5];
        c.op    = word[CTRL_RD_BIT] ? OP_READ : OP_WRITE;
        return c;
    endfunction

endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt >= div);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: MDC only moves while a frame is running
    a_r4_mdc_moves_only_when_running: assert property (@(posedge clk) disable iff (rst)
        (mdc != $past(mdc)) |-> $past(run));

    // R4: MDC rests low outside frames
    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      start_req,
    input  mdio_cmd_t cmd,
    input  logic [15:0] wdata,
    input  logic      rise,
    input  logic      fall,
    input  logic      mdio_i,
    output logic      busy,
    output logic      mdio_o,
    output logic      mdio_oe,
    output logic [15:0] rdata
);

    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TA_C   = CNT_W'(PRE_LEN + 14);
    localparam logic [CNT_W-1:0] DATA_C = CNT_W'(PRE_LEN + 16);

    logic [FRAME_LEN-1:0] sh;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 is_rd;
    logic                 accept;
    logic                 cmd_rd;

    assign accept = start_req && en && !busy;
    assign cmd_rd = (cmd.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sh      <= '0;
            bit_cnt <= '0;
            is_rd   <= 1'b0;
            rdata   <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
            is_rd   <= cmd_rd;
            sh      <= {{PRE_LEN{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad,
                        (cmd_rd ? 2'b11 : 2'b10), (cmd_rd ? 16'hFFFF : wdata)};
        end else if (busy) begin
            if (rise && is_rd && (bit_cnt >= DATA_C))
                rdata <= {rdata[14:0], mdio_i};
            if (fall) begin
                if (bit_cnt == LAST_C) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    sh      <= {sh[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    assign mdio_o  = sh[FRAME_LEN-1];
    assign mdio_oe = busy && !(is_rd && (bit_cnt >= TA_C));

    // R7: a start seen during a frame never restarts the bit counter
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req) |=> (bit_cnt >= $past(bit_cnt)));

    // R7: no frame begins while the interface is disabled
    a_r7_disabled_no_start: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !busy);

    // R5: a frame ends only after its last bit
    a_r5_full_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(bit_cnt) == LAST_C));

    // R6: once released during a read, the line stays released until the frame ends
    a_r6_release_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !mdio_oe) |=> (!mdio_oe || !busy));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DIV_W     = 6,
    parameter int DIV_RESET = 29,
    parameter int PRE_LEN   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(OFS_WDAT);
    localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(OFS_RDAT);

    logic [DIV_W-1:0] div_q;
    logic             en_q;
    mdio_cmd_t        cmd_q;
    mdio_cmd_t        cmd_in;
    logic [15:0]      wdat_q;
    logic [15:0]      rdat;
    logic             wr_cfg, wr_ctrl, wr_wdat, start_req;
    logic             rise, fall;
    logic             unused_wbits;

    assign wr_cfg    = reg_wr && (reg_addr == A_CFG);
    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_wdat   = reg_wr && (reg_addr == A_WDAT);
    assign cmd_in    = decode_cmd(reg_wdata);
    assign start_req = wr_ctrl && reg_wdata[CTRL_GO_BIT];
    assign unused_wbits = ^{reg_wdata[31:29], reg_wdata[23:21]};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_RESET);
            en_q   <= 1'b0;
            cmd_q  <= '{phy: '0, regad: '0, op: OP_NONE};
            wdat_q <= '0;
        end else begin
            if (wr_cfg) begin
                div_q <= reg_wdata[DIV_W-1:0];
                en_q  <= reg_wdata[CFG_EN_BIT];
            end
            if (wr_ctrl && !busy)
                cmd_q <= cmd_in;
            if (wr_wdat)
                wdat_q <= reg_wdata[15:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[DIV_W-1:0]  = div_q;
                reg_rdata[CFG_EN_BIT] = en_q;
            end
            A_CTRL: begin
                reg_rdata[CTRL_PHY_LSB +: 5] = cmd_q.phy;
                reg_rdata[CTRL_REG_LSB +: 5] = cmd_q.regad;
                reg_rdata[CTRL_RD_BIT]       = cmd_q.op[1];
                reg_rdata[CTRL_WR_BIT]       = cmd_q.op[0];
                reg_rdata[CTRL_RDY_BIT]      = !busy;
            end
            A_WDAT:  reg_rdata[15:0] = wdat_q;
            A_RDAT:  reg_rdata[15:0] = rdat;
            default: reg_rdata = '0;
        endcase
    end

    mdc_clock_gen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_q),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .start_req (start_req),
        .cmd       (cmd_in),
        .wdata     (wdat_q),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (rdat)
    );

    // R9: the data line holds still across each MDC high phase
    a_r9_mdio_steady_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R7: the stored command does not change while a frame runs
    a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] data;
        logic [5:0]  div;
        logic        present;
        logic        inject;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'h01, 5'h00, 16'hA5C3, 6'd1,  1'b1, 1'b0},
        '{1'b1, 5'h1F, 5'h01, 16'h796D, 6'd2,  1'b1, 1'b1},
        '{1'b1, 5'h0A, 5'h1E, 16'h0000, 6'd0,  1'b0, 1'b0},
        '{1'b0, 5'h15, 5'h0B, 16'h0001, 6'd3,  1'b1, 1'b1},
        '{1'b1, 5'h03, 5'h11, 16'h1234, 6'd29, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, busy;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = !clk;

    mdio_mgmt_master dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .busy(busy)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input vec_t v);
        return (32'(v.phy) << 24) | (32'(v.ra) << 16) |
               (v.rd ? 32'h8000 : 32'h4000) | 32'h0800;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] cap, oecap, exp_f, exp_oe;
        int cyc, rises, last, first_rise, bad_period;
        logic prev, saw_mdc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(12'h500, r); check("R1 cfg reset", 64'(r), 64'h1D);
        rd(12'h504, r); check("R1 ctrl reset", 64'(r), 64'h80);
        rd(12'h50C, r); check("R1 rdata reset", 64'(r), 64'h0);
        check("R1 pins idle", {61'b0, mdc, mdio_oe, busy}, 64'h0);

        // R2: register readback
        wr(12'h500, 32'h0000_0045);
        rd(12'h500, r); check("R2 cfg readback", 64'(r), 64'h45);
        wr(12'h508, 32'hFFFF_BEEF);
        rd(12'h508, r); check("R2 wdata readback", 64'(r), 64'hBEEF);

        // R7: start with enable clear is ignored
        wr(12'h500, 32'h0000_0001);
        wr(12'h504, 32'h0101_C800);
        saw_mdc = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdc || busy) saw_mdc = 1'b1;
        end
        check("R7 disabled start no activity", 64'(saw_mdc), 64'h0);
        rd(12'h504, r); check("R7 disabled start ready", 64'(r[7]), 64'h1);

        // Table of frames: R3 R4 R5 R6 R8 R9
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            wr(12'h500, 32'h40 | 32'(v.div));
            if (!v.rd) wr(12'h508, 32'(v.data));
            rd(12'h504, r); check($sformatf("R3 ready before frame %0d", k), 64'(r[7]), 64'h1);
            wr(12'h504, ctrl_word(v));
            cyc = 0; rises = 0; last = 0; first_rise = -1; bad_period = 0;
            cap = '0; oecap = '0; prev = mdc; mdio_i = 1'b1;
            while (!(rises == 64 && !busy) && cyc < 5000) begin
                @(negedge clk);
                cyc++;
                if (v.inject && cyc == 5) begin
                    reg_wr = 1'b1; reg_addr = 12'h504;
                    reg_wdata = 32'h0707_0800;
                end else if (cyc == 6) begin
                    reg_wr = 1'b0;
                end
                if (mdc && !prev) begin
                    cap[63-rises]   = mdio_o;
                    oecap[63-rises] = mdio_oe;
                    if (rises == 0) first_rise = cyc;
                    else if (cyc - last != 2 * (int'(v.div) + 1)) bad_period++;
                    last = cyc;
                    rises++;
                end
                prev = mdc;
                if (v.present && v.rd && rises >= 47 && rises <= 63)
                    mdio_i = (rises == 47) ? 1'b0 : v.data[63-rises];
                else
                    mdio_i = 1'b1;
            end
            exp_f  = {32'hFFFF_FFFF, 2'b01, (v.rd ? 2'b10 : 2'b01), v.phy, v.ra,
                      (v.rd ? 2'b11 : 2'b10), (v.rd ? 16'hFFFF : v.data)};
            exp_oe = v.rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
            check($sformatf("R5 frame bits row %0d", k), cap & exp_oe, exp_f & exp_oe);
            check($sformatf("R6 output enable row %0d", k), oecap, exp_oe);
            check($sformatf("R4 first rise row %0d", k), 64'(first_rise), 64'(int'(v.div) + 1));
            check($sformatf("R4 period row %0d", k), 64'(bad_period), 64'h0);
            rd(12'h504, r);
            check($sformatf("R3 R7 ctrl after row %0d", k), 64'(r),
                  64'((ctrl_word(v) & ~32'h0800) | 32'h80));
            if (v.rd) begin
                rd(12'h50C, r);
                check($sformatf("%s rdata row %0d", v.present ? "R6" : "R8", k),
                      64'(r), v.present ? 64'(v.data) : 64'hFFFF);
            end else begin
                check($sformatf("R9 mdc low after row %0d", k), 64'(mdc), 64'h0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule